// File: doc/BRIEF.md
# Input-Registered Single-Port Word RAM

This block is a small word-addressed RAM, 32 words of 8 bits by default. On each rising clock edge it captures the address, write data and write enable into registers. The read data is not registered. It is a combinational selection of the stored word at the captured address, so a read is visible in the same cycle that its address was captured. Write data and read data use separate ports.

A captured write is committed to the array on the following clock edge. The committed word is the one at the captured address, and the value is the captured data. Because the output always follows the array at the registered address, a committed write shows up on the output as soon as the array changes, provided the address is held.

An active-high synchronous reset clears the three input registers. It does not touch the stored words. A write that was captured but not yet committed when reset is sampled is discarded.

Top module: `regin_sp_ram`

## Requirements
- R1: On a clock edge with `rst` high, the registered address becomes 0 and the registered write enable becomes 0. In the next cycle `rdata_o` therefore shows word 0, and the stored words are unchanged.
- R2: On a clock edge with `rst` low, `addr_i` is captured. From that edge until the next one, `rdata_o` equals the stored word at the captured address, with no further latency.
- R3: A write captured at edge k (`we_i` high) is committed at edge k+1. The word at the address captured at k is loaded with the data captured at k, whatever the inputs are at k+1.
- R4: When the captured address still points at the word committed at an edge, `rdata_o` shows the new value right after that edge.
- R5: An edge whose registered write enable is 0 leaves every stored word unchanged. Reading a word does not alter it.
- R6: Changes on `addr_i`, `wdata_i` and `we_i` between clock edges do not change `rdata_o`.
- R7: A captured write that is still pending at an edge where `rst` is high is dropped. Its target word keeps its old value.
- R8: Writes on consecutive cycles each commit in order. When they target the same word, the last one is kept.
- R9: Every address from 0 to DEPTH-1 selects its own word, and each word holds its value independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all registers and the array |
| rst | input | 1 | Synchronous reset of the input registers, active high |
| addr_i | input | ADDR_W (5) | Word address, captured on the rising edge |
| wdata_i | input | WIDTH (8) | Write data, captured on the rising edge |
| we_i | input | 1 | Write request, captured on the rising edge |
| rdata_o | output | WIDTH (8) | Word at the registered address, combinational |

## Verification
Two things can happen at the same edge: the commit of the previously captured write, and the capture of a new address and command. The bench provokes this overlap in three ways. It issues back-to-back writes to the same word and to different words. It changes the address in the cycle after a write. It raises reset on the cycle after a write. In each case a scoreboard model applies the commit before the capture, and its prediction of the output is compared a few nanoseconds after the next falling edge, once the driver has already moved the inputs.

// File: rtl/regin_sp_ram_pkg.sv
package regin_sp_ram_pkg;

  localparam int unsigned RAM_DEPTH_DEF = 32;
  localparam int unsigned RAM_WIDTH_DEF = 8;

  // Address bits needed for a given word count (at least one bit).
  function automatic int unsigned addr_bits(input int unsigned depth);
    int unsigned n;
    n = 1;
    while ((1 << n) < depth) n++;
    return n;
  endfunction

  // True when the depth fills the whole address space.
  function automatic bit depth_is_pow2(input int unsigned depth);
    return (depth != 0) && ((depth & (depth - 1)) == 0);
  endfunction

  // Word-select match used by the write decoder.
  function automatic bit word_hit(input int unsigned idx, input int unsigned addr);
    return idx == addr;
  endfunction

endpackage

// File: rtl/regin_sp_ram_in_stage.sv
module regin_sp_ram_in_stage #(
  parameter int ADDR_W = 5,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              we_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WIDTH-1:0]  wdata_q,
  output logic              we_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
    end
  end

endmodule

// File: rtl/regin_sp_ram_store.sv
module regin_sp_ram_store
  import regin_sp_ram_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] words
);

  logic [DEPTH-1:0] wr_sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign wr_sel[i] = wr_en && word_hit(i, int'(wr_addr));

    // No reset on the stored words: contents survive a reset.
    always_ff @(posedge clk) begin
      if (wr_sel[i]) words[i] <= wr_data;
    end
  end

endmodule

// File: rtl/regin_sp_ram_rd_mux.sv
module regin_sp_ram_rd_mux
  import regin_sp_ram_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] words,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WIDTH-1:0]            rd_data
);

  if (depth_is_pow2(DEPTH) && (DEPTH == (1 << ADDR_W))) begin : g_full
    assign rd_data = words[rd_addr];
  end else begin : g_partial
    // Addresses past the last word read as zero.
    always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (int'(rd_addr) == i) rd_data = words[i];
      end
    end
  end

endmodule

// File: rtl/regin_sp_ram.sv
module regin_sp_ram
  import regin_sp_ram_pkg::*;
#(
  parameter int DEPTH  = RAM_DEPTH_DEF,
  parameter int WIDTH  = RAM_WIDTH_DEF,
  parameter int ADDR_W = addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              we_i,
  output logic [WIDTH-1:0]  rdata_o
);

  // Registered command
  logic [ADDR_W-1:0] rd_addr;
  logic [WIDTH-1:0]  wdata_q;
  logic              we_q;

  // Named commit event, seen by the checker
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [WIDTH-1:0]  commit_data;

  logic [DEPTH-1:0][WIDTH-1:0] words;

  regin_sp_ram_in_stage #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_in (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .addr_q  (rd_addr),
    .wdata_q (wdata_q),
    .we_q    (we_q)
  );

  // A pending write is dropped on a reset edge.
  assign commit_en   = we_q && !rst;
  assign commit_addr = rd_addr;
  assign commit_data = wdata_q;

  regin_sp_ram_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (commit_en),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .words   (words)
  );

  regin_sp_ram_rd_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
    .words   (words),
    .rd_addr (rd_addr),
    .rd_data (rdata_o)
  );

endmodule

// File: rtl/regin_sp_ram_chk.sv
module regin_sp_ram_chk #(
  parameter int ADDR_W = 5,
  parameter int WIDTH  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              we_q,
  input logic              commit_en,
  input logic [ADDR_W-1:0] commit_addr,
  input logic [WIDTH-1:0]  commit_data,
  input logic [WIDTH-1:0]  rdata_o
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_addr == '0 && !we_q)); // R1

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_addr == $past(addr_i))); // R2

  AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> (rd_addr != $past(commit_addr) || rdata_o == $past(commit_data))); // R4

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> (rd_addr != $past(rd_addr) || $stable(rdata_o))); // R5

endmodule

bind regin_sp_ram regin_sp_ram_chk #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .rd_addr     (rd_addr),
  .we_q        (we_q),
  .commit_en   (commit_en),
  .commit_addr (commit_addr),
  .commit_data (commit_data),
  .rdata_o     (rdata_o)
);

// File: tb/tb_regin_sp_ram.sv
module tb_regin_sp_ram;

  localparam int DEPTH = 32;
  localparam int WIDTH = 8;
  localparam int AW    = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [AW-1:0]    addr_i = '0;
  logic [WIDTH-1:0] wdata_i = '0;
  logic             we_i = 1'b0;
  logic [WIDTH-1:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  regin_sp_ram dut (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .rdata_o (rdata_o)
  );

  typedef struct {
    logic [WIDTH-1:0] exp;
    string            tag;
  } item_t;

  item_t q[$];

  // Scoreboard model of the requirements
  logic [WIDTH-1:0] m_mem [DEPTH];
  logic [AW-1:0]    m_addr = '0;
  logic [WIDTH-1:0] m_data = '0;
  logic             m_we   = 1'b0;

  function automatic logic [WIDTH-1:0] pat(input int i);
    return WIDTH'((i * 37 + 11) ^ 8'h5A);
  endfunction

  // Driver: inputs at the falling edge, model step at the rising edge.
  task automatic cycle(input logic [AW-1:0] a, input logic [WIDTH-1:0] d,
                       input logic w, input logic r, input string tag);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = w; rst = r;
    @(posedge clk);
    if (!r && m_we) m_mem[m_addr] = m_data;   // R3 commit before capture
    if (r) begin m_addr = '0; m_data = '0; m_we = 1'b0; end
    else   begin m_addr = a;  m_data = d;  m_we = w;    end
    q.push_back('{exp: m_mem[m_addr], tag: tag});
  endtask

  // Monitor: samples after the driver has already moved the inputs (R6).
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (rdata_o !== e.exp) begin
          fails++;
          $display("FAIL %s: rdata_o actual %h expected %h", e.tag, rdata_o, e.exp);
        end
      end
    end
  end

  initial begin
    cycle(0, 0, 0, 1, "R1");
    cycle(0, 0, 0, 1, "R1");
    // R9: fill every word, word 0 last
    for (int i = 1; i < DEPTH; i++) cycle(AW'(i), pat(i), 1'b1, 1'b0, "R9");
    cycle(0, pat(0), 1, 0, "R9");
    // R2: read every word back, one address per cycle
    for (int i = 0; i < DEPTH; i++) cycle(AW'(i), 8'hFF, 1'b0, 1'b0, "R2");
    // R3/R4/R5: write word 5 then hold the address
    cycle(5, 8'hAA, 1, 0, "R3");
    cycle(5, 8'h00, 0, 0, "R4");
    cycle(5, 8'h33, 0, 0, "R5");
    // R3: address moves right after the write
    cycle(3, 8'h55, 1, 0, "R3");
    cycle(4, 8'h99, 0, 0, "R3");
    cycle(3, 8'h00, 0, 0, "R3");
    // R8: back-to-back writes, same word then different words
    cycle(7, 8'h11, 1, 0, "R8");
    cycle(7, 8'h22, 1, 0, "R8");
    cycle(8, 8'h44, 1, 0, "R8");
    cycle(7, 8'h00, 0, 0, "R8");
    cycle(8, 8'h00, 0, 0, "R8");
    // R7: write then reset on the next edge
    cycle(9, 8'hCC, 1, 0, "R7");
    cycle(9, 8'hEE, 1, 1, "R1");
    cycle(9, 8'h00, 0, 0, "R7");
    cycle(0, 8'h00, 0, 0, "R1");
    // R5: reads of every word leave contents intact
    for (int i = 0; i < DEPTH; i++) cycle(AW'(DEPTH - 1 - i), 8'h00, 1'b0, 1'b0, "R5");
    @(negedge clk);
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule